// File: doc/BRIEF.md
# Module Clock Divider with Phase Taps

This block derives a module clock from one of several source clocks and adds two phase-shifted copies of it. It is built around one functional clock `clk`. Each source appears as a one-cycle strobe on `src_tick`, and one strobe marks one source period. The selected source is divided by a power of two and then by an integer. The result appears on `mod_clk` as a level that changes only on source strobes.

Two taps follow the divided clock. The output-phase tap and the sample-phase tap are each delayed by a whole number of source periods. A zero delay setting instead inverts the divided clock, which is a half-period shift. Everything is set through one 32-bit configuration word that is written and read over a simple port.

The source may only be changed while the clock is disabled. Divide and delay changes made while the clock runs are applied at the start of the next divided period.

Top module: `mclkdiv`

## Requirements
- R1: `cfg_rdata` returns the last word written, masked so that only these fields are kept: divider M in bits 3:0, output-phase field in bits 11:8, pre-divide exponent P in bits 17:16, sample-phase field in bits 23:20, source select in bits 24 upward (log2 of NSRC bits), and enable in bit 31. All other bits read as zero. With sixteen sources, writing all ones reads back 0x8FF30F0F.
- R2: While enabled, `mod_clk` has a period of N = (M+1)·2^P strobes of the selected source.
- R3: Each divided period begins with `mod_clk` high for ceil(N/2) strobes, followed by low for the rest of the period. When N = 1, `mod_clk` stays high.
- R4: While bit 31 is low, all three outputs are low and the divider and delay state is cleared. After enabling, the first strobe of the selected source starts a new period with `mod_clk` rising.
- R5: Only strobes of the source chosen by the select field advance the outputs. Strobes on other sources change nothing.
- R6: The output-phase tap uses the two low bits of its field as a delay D. For D = 1 to 3, the tap equals `mod_clk` delayed by D strobes, which is a phase of D·round(360/N) degrees.
- R7: The sample-phase tap behaves the same way, using the two low bits of bits 23:20.
- R8: With D = 0, a tap is the inverse of `mod_clk` while the clock is enabled.
- R9: New M, P or delay values take effect only at the strobe that starts the next divided period. The period already running completes with the old values.
- R10: During reset, `cfg_rdata` is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One strobe per source period, one bit per source |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| mod_clk | output | 1 | Divided module clock |
| out_phase_clk | output | 1 | Output-phase tap |
| smp_phase_clk | output | 1 | Sample-phase tap |

## Verification
The bench builds the block with NSRC = 16. This makes the select field four bits wide and gives every source a different strobe rate (source i strobes every i+1 cycles). Sources above index 3 and the full 0x8FF30F0F readback mask then become reachable, and measured periods depend on which source is selected. The default P and M widths span ratios from 1 up to 128. Together with a reference model, this covers odd ratios, ratio 1, phase steps of 90 and 270 degrees at N = 4, and a divide change made mid-period.

// File: rtl/mclkdiv_pkg.sv
package mclkdiv_pkg;
  localparam int M_LSB   = 0;
  localparam int M_W     = 4;
  localparam int OPH_LSB = 8;
  localparam int PH_W    = 4;
  localparam int DLY_W   = 2;
  localparam int P_LSB   = 16;
  localparam int P_W     = 2;
  localparam int SPH_LSB = 20;
  localparam int SEL_LSB = 24;
  localparam int EN_BIT  = 31;
  localparam int CNT_W   = M_W + (2**P_W) - 1;

  typedef struct packed {
    logic [DLY_W-1:0] sph;
    logic [DLY_W-1:0] oph;
    logic [P_W-1:0]   p;
    logic [M_W-1:0]   m;
  } div_cfg_t;

  function automatic logic [31:0] field_mask(int selw);
    logic [31:0] r;
    r = '0;
    r[M_LSB+:M_W]     = '1;
    r[OPH_LSB+:PH_W]  = '1;
    r[P_LSB+:P_W]     = '1;
    r[SPH_LSB+:PH_W]  = '1;
    for (int i = 0; i < selw; i++) r[SEL_LSB+i] = 1'b1;
    r[EN_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mclkdiv_cfg.sv
module mclkdiv_cfg
  import mclkdiv_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             en,
  output logic [SEL_W-1:0] sel,
  output div_cfg_t         fields
);
  localparam logic [31:0] MASK = field_mask(SEL_W);

  logic [31:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (we) word_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (we) word_q <= word_d;
  end

  assign rdata      = word_q;
  assign en         = word_q[EN_BIT];
  assign sel        = word_q[SEL_LSB+:SEL_W];
  assign fields.m   = word_q[M_LSB+:M_W];
  assign fields.p   = word_q[P_LSB+:P_W];
  assign fields.oph = word_q[OPH_LSB+:DLY_W];
  assign fields.sph = word_q[SPH_LSB+:DLY_W];
endmodule

// File: rtl/mclkdiv_core.sv
module mclkdiv_core
  import mclkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  div_cfg_t pend,
  output logic     main_q,
  output div_cfg_t act
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             main_d;
  div_cfg_t         act_q, act_d, eff;
  logic [CNT_W:0]   m_ext, n_eff, half, cnt_inc;
  logic             upd;

  always_comb begin
    eff     = (cnt_q == '0) ? pend : act_q;
    m_ext   = (CNT_W+1)'(eff.m) + 1'b1;
    n_eff   = m_ext << eff.p;
    half    = (n_eff + 1'b1) >> 1;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    upd     = !en || tick;
    cnt_d   = cnt_q;
    main_d  = main_q;
    act_d   = act_q;
    if (!en) begin
      cnt_d  = '0;
      main_d = 1'b0;
      act_d  = pend;
    end else if (tick) begin
      main_d = ({1'b0, cnt_q} < half);
      act_d  = eff;
      if (cnt_inc >= n_eff) cnt_d = '0;
      else                  cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      main_q <= 1'b0;
      act_q  <= '0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      main_q <= main_d;
      act_q  <= act_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/mclkdiv_hist.sv
module mclkdiv_hist #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             main_q,
  output logic [DEPTH-1:0] hist
);
  logic [DEPTH-1:0] hist_q, hist_d;
  logic             upd;

  always_comb begin
    upd    = !en || tick;
    hist_d = hist_q;
    if (!en)       hist_d = '0;
    else if (tick) hist_d = {hist_q[DEPTH-2:0], main_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist_q <= '0;
    else if (upd) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/mclkdiv_pick.sv
module mclkdiv_pick #(
  parameter int DLY_W = 2,
  parameter int DEPTH = 3
) (
  input  logic             en,
  input  logic             main_q,
  input  logic [DEPTH-1:0] hist,
  input  logic [DLY_W-1:0] dly,
  output logic             tap
);
  logic pick;

  always_comb begin
    pick = ~main_q;
    for (int i = 1; i <= DEPTH; i++) begin
      if (dly == DLY_W'(i)) pick = hist[i-1];
    end
  end

  assign tap = en & pick;
endmodule

// File: rtl/mclkdiv.sv
module mclkdiv
  import mclkdiv_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            mod_clk,
  output logic            out_phase_clk,
  output logic            smp_phase_clk
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DEPTH = (2**DLY_W) - 1;
  localparam int NTAP  = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             en;
  logic [SEL_W-1:0] sel;
  logic             tick;
  div_cfg_t         pend, act_cfg;
  logic             main_q;
  logic [DEPTH-1:0] hist;
  logic [DLY_W-1:0] oph_act;
  logic [DLY_W-1:0] dly_arr [NTAP];
  logic [NTAP-1:0]  taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mclkdiv_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .en     (en),
    .sel    (sel),
    .fields (pend)
  );

  assign tick = src_tick[sel];

  mclkdiv_core u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (en),
    .tick   (tick),
    .pend   (pend),
    .main_q (main_q),
    .act    (act_cfg)
  );

  mclkdiv_hist #(.DEPTH(DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (en),
    .tick   (tick),
    .main_q (main_q),
    .hist   (hist)
  );

  assign dly_arr[0] = act_cfg.oph;
  assign dly_arr[1] = act_cfg.sph;
  assign oph_act    = act_cfg.oph;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    mclkdiv_pick #(.DLY_W(DLY_W), .DEPTH(DEPTH)) u_pick (
      .en     (en),
      .main_q (main_q),
      .hist   (hist),
      .dly    (dly_arr[g]),
      .tap    (taps[g])
    );
  end

  assign mod_clk       = en & main_q;
  assign out_phase_clk = taps[0];
  assign smp_phase_clk = taps[1];
endmodule

// File: rtl/mclkdiv_chk.sv
module mclkdiv_chk
  import mclkdiv_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_tick,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             mod_clk,
  input logic             out_phase_clk,
  input logic             smp_phase_clk,
  input logic [DLY_W-1:0] oph_act
);
  localparam logic [31:0] MASK = field_mask(SEL_W);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[EN_BIT] |-> (!mod_clk && !out_phase_clk && !smp_phase_clk)); // R4

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & MASK))); // R1

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~MASK) == 32'd0); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[EN_BIT] && src_tick == '0 && !cfg_we)
      |=> ($stable(mod_clk) && $stable(out_phase_clk) && $stable(smp_phase_clk))); // R5

  AST_ZERO_DLY_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[EN_BIT] && oph_act == '0) |-> (out_phase_clk == !mod_clk)); // R8
endmodule

bind mclkdiv mclkdiv_chk #(.NSRC(NSRC), .SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .src_tick      (src_tick),
  .cfg_we        (cfg_we),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .mod_clk       (mod_clk),
  .out_phase_clk (out_phase_clk),
  .smp_phase_clk (smp_phase_clk),
  .oph_act       (oph_act)
);

// File: tb/sim_mclkdiv.sv
`timescale 1ns/1ps
module sim_mclkdiv;
  localparam int NSRC = 16;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src_tick;
  logic            cfg_we;
  logic [31:0]     cfg_wdata;
  logic [31:0]     cfg_rdata;
  logic            mod_clk, out_phase_clk, smp_phase_clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_on = 0;
  string scen = "R10";

  // reference model state
  logic [31:0] mc;
  int cnt, am, ap, ao, as_, h1, h2, h3;
  bit mq;

  // edge monitor
  int t_main = 0, t_main_prev = 0, per_main = 0, lat_o = -1, lat_s = -1;
  bit pm = 0, po = 0, ps = 0;

  mclkdiv #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mod_clk(mod_clk),
    .out_phase_clk(out_phase_clk), .smp_phase_clk(smp_phase_clk)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit tap_exp(int d);
    bit v;
    case (d)
      0: v = !mq;
      1: v = h1[0];
      2: v = h2[0];
      default: v = h3[0];
    endcase
    return mc[31] & v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = '0; cnt = 0; mq = 0; h1 = 0; h2 = 0; h3 = 0;
      am = 0; ap = 0; ao = 0; as_ = 0;
    end else begin
      int sel, n, half;
      bit nm;
      sel = int'(mc[27:24]);
      if (!mc[31]) begin
        cnt = 0; mq = 0; h1 = 0; h2 = 0; h3 = 0;
        am = int'(mc[3:0]); ap = int'(mc[17:16]);
        ao = int'(mc[9:8]); as_ = int'(mc[21:20]);
      end else if (src_tick[sel]) begin
        if (cnt == 0) begin
          am = int'(mc[3:0]); ap = int'(mc[17:16]);
          ao = int'(mc[9:8]); as_ = int'(mc[21:20]);
        end
        n = (am + 1) << ap;
        half = (n + 1) / 2;
        nm = (cnt < half);
        h3 = h2; h2 = h1; h1 = int'(mq);
        mq = nm;
        cnt = (cnt + 1 >= n) ? 0 : cnt + 1;
      end
      if (cfg_we) mc = cfg_wdata & 32'h8FF30F0F;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(mod_clk == (mc[31] & mq), {"R2 R3 ", scen}, "mod_clk", mod_clk, mc[31] & mq);
      chk(out_phase_clk == tap_exp(ao), {"R6 ", scen}, "out_phase_clk", out_phase_clk, tap_exp(ao));
      chk(smp_phase_clk == tap_exp(as_), {"R7 ", scen}, "smp_phase_clk", smp_phase_clk, tap_exp(as_));
    end
    if (mod_clk && !pm) begin
      t_main_prev = t_main; t_main = cyc; per_main = t_main - t_main_prev;
    end
    if (out_phase_clk && !po) lat_o = cyc - t_main;
    if (smp_phase_clk && !ps) lat_s = cyc - t_main;
    pm = mod_clk; po = out_phase_clk; ps = smp_phase_clk;
    cyc = cyc + 1;
    for (int i = 0; i < NSRC; i++) src_tick[i] = ((cyc % (i + 1)) == 0);
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int step;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; src_tick = '0;
    idle(5);
    chk(cfg_rdata == 32'd0, "R10", "rdata in reset", cfg_rdata, 0);
    chk({mod_clk, out_phase_clk, smp_phase_clk} == 3'b000, "R10", "outputs in reset",
        {mod_clk, out_phase_clk, smp_phase_clk}, 0);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1;

    // N=4, source 0, delays 1 and 3
    scen = "R6 R7";
    wr(32'h8030_0103);
    idle(30);
    step = (360 + 2) / 4;
    chk(lat_o * step == 1 * step, "R6", "out tap phase deg", lat_o * step, 90);
    chk(lat_s * step == 3 * step, "R7", "smp tap phase deg", lat_s * step, 270);
    chk(per_main == 4, "R2", "period N=4", per_main, 4);

    // divide change mid-period
    scen = "R9";
    idle(1);
    wr(32'h8030_0101);
    idle(20);
    chk(per_main == 2, "R9", "period after change", per_main, 2);

    // odd ratio, zero delays, source 1
    scen = "R3 R8";
    wr(32'h8100_0002);
    idle(40);
    chk(per_main == 6, "R2", "N=3 on source 1 period", per_main, 6);
    chk(out_phase_clk == !mod_clk, "R8", "inverted tap", out_phase_clk, !mod_clk);

    // ratio 1
    scen = "R3";
    wr(32'h8000_0000);
    idle(10);
    chk(mod_clk == 1'b1, "R3", "ratio one steady high", mod_clk, 1);

    // N=10 on source 2
    scen = "R2";
    wr(32'h8211_0204);
    idle(80);
    chk(per_main == 30, "R2", "N=10 on source 2 period", per_main, 30);

    // disable, reselect while off, enable
    scen = "R4";
    wr(32'h0211_0204);
    idle(3);
    chk({mod_clk, out_phase_clk, smp_phase_clk} == 3'b000, "R4", "outputs when off",
        {mod_clk, out_phase_clk, smp_phase_clk}, 0);
    scen = "R5";
    wr(32'h0311_0204);
    wr(32'h8311_0204);
    idle(100);
    chk(per_main == 40, "R5", "period on source 3", per_main, 40);

    // readback mask
    scen = "R1";
    wr(32'hFFFF_FFFF);
    idle(2);
    chk(cfg_rdata == 32'h8FF3_0F0F, "R1", "masked readback", cfg_rdata, 32'h8FF30F0F);
    idle(300);
    wr(32'h0000_0000);
    idle(2);
    chk(cfg_rdata == 32'd0, "R1", "readback zero", cfg_rdata, 0);
    chk({mod_clk, out_phase_clk, smp_phase_clk} == 3'b000, "R4", "outputs after disable",
        {mod_clk, out_phase_clk, smp_phase_clk}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule